// File: doc/BRIEF.md
# Programmable Bus Wait-State Inserter

This block lengthens an external bus cycle by holding the bus state sequencer between its third and fourth states for a software-chosen number of half-clock wait states. A three-bit setting, written through a simple register port, selects one of eight stretch lengths. The length is twice the setting, so the choices run from no wait at all up to fourteen half-clock states. The sequencer reports when its third state has finished. On that half-clock tick the block loads the programmed length and raises a hold output. It then counts down one step per half-clock tick and drops the hold once the count is spent, so the fourth state can go ahead.

Stretching applies only to accesses that leave the chip. When the access targets internal registers or internal memory, or when the system clock comes from the low-speed oscillator, the block ignores the end of the third state and the sequencer runs straight on. The remaining count is brought out so the sequencer or a debug path can see how far a stretch has progressed.

Top module: `bus_wait_stretcher`

## Requirements
- R1: After reset the setting reads back as 000, the hold output is low and the remaining count is 0.
- R2: A write strobe stores the three-bit write data in the setting, and the setting reads back on the next cycle.
- R3: On an external access with the fast clock, the stretch length is twice the setting: code 111 gives 14 half-clock wait states, 110 gives 12, and so on down to 001, which gives 2.
- R4: Setting 000 inserts no wait states. The hold stays low.
- R5: If a half-clock tick coincides with third-state-complete and a stretch applies, the hold is high and the remaining count equals the stretch length from the next clock edge onward.
- R6: While holding, the remaining count drops by exactly one on each half-clock tick and does not change on clocks without a tick. The hold falls together with the tick that brings the count to 0.
- R7: An access with the external-access flag low never raises the hold.
- R8: While the slow-oscillator flag is high, the hold is never raised.
- R9: A write during an active stretch leaves the current stretch length unchanged. The new setting governs the next bus cycle.
- R10: A third-state-complete indication that arrives while the hold is high neither restarts nor extends the current stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle pulse per bus half-clock state |
| t3_done | input | 1 | Sequencer has finished its third state (qualified by half_tick) |
| ext_access | input | 1 | Current access targets an off-chip device |
| slow_osc | input | 1 | System clock is taken from the low-speed oscillator |
| cfg_we | input | 1 | Write strobe for the wait setting |
| cfg_wdata | input | CODE_W | New wait setting |
| cfg_rdata | output | CODE_W | Current wait setting |
| wait_hold | output | 1 | Stall request to the bus state sequencer |
| wait_left | output | CNT_W | Half-clock wait states still to run |

## Verification
The bench sweeps all eight settings against all four combinations of external access and slow oscillator. A design with a wrong code-to-length scale, or one that fails to gate internal or slow-clock accesses, would show a hold of the wrong length or a hold where none belongs. Between ticks it checks that the count holds still; a design that counted clocks instead of ticks would end its stretches early. It rewrites the setting in the middle of a stretch and pulses third-state-complete during a hold. A design that read the register live, or reloaded on a repeated trigger, would lengthen or shorten the stretch under way.

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_HOLD = 1'b1
   } ws_state_e;

   function automatic int unsigned bws_len_width(input int unsigned code_w,
                                                 input int unsigned step);
      int unsigned max_len;
      max_len = ((1 << code_w) - 1) * step;
      return (max_len < 2) ? 1 : $clog2(max_len + 1);
   endfunction
endpackage

// File: rtl/bws_cfg_reg.sv
module bws_cfg_reg #(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned RESET_CODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] code_q
);
   generate
      if (RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
         $error("bws_cfg_reg: RESET_CODE does not fit in CODE_W bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_W'(RESET_CODE);
      end else if (wr_en) begin
         code_q <= wr_data;
      end
   end
endmodule

// File: rtl/bws_len_map.sv
module bws_len_map #(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned STEP   = 2,
   parameter int unsigned CNT_W  = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  len
);
   localparam bit STEP_IS_POW2 = (STEP != 0) && ((STEP & (STEP - 1)) == 0);
   localparam int unsigned STEP_SHIFT = (STEP > 1) ? $clog2(STEP) : 0;

   generate
      if (STEP == 0) begin : g_bad_step
         $error("bws_len_map: STEP must be non-zero");
      end
      if (STEP_IS_POW2) begin : g_shift
         always_comb len = CNT_W'(code) << STEP_SHIFT;
      end else begin : g_mult
         always_comb len = CNT_W'(code) * CNT_W'(STEP);
      end
   endgenerate
endmodule

// File: rtl/bws_counter.sv
module bws_counter
   import bws_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             hold,
   output logic [CNT_W-1:0] left
);
   ws_state_e        state_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         left_q  <= '0;
      end else if (tick) begin
         unique case (state_q)
            WS_IDLE: begin
               if (start && (len != '0)) begin
                  left_q  <= len;
                  state_q <= WS_HOLD;
               end
            end
            WS_HOLD: begin
               left_q <= left_q - CNT_W'(1);
               if (left_q == CNT_W'(1)) begin
                  state_q <= WS_IDLE;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign hold = (state_q == WS_HOLD);
   assign left = left_q;
endmodule

// File: rtl/bus_wait_stretcher.sv
module bus_wait_stretcher #(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned STEP       = 2,
   parameter int unsigned RESET_CODE = 0,
   parameter int unsigned CNT_W      = bws_pkg::bws_len_width(CODE_W, STEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic              t3_done,
   input  logic              ext_access,
   input  logic              slow_osc,
   input  logic              cfg_we,
   input  logic [CODE_W-1:0] cfg_wdata,
   output logic [CODE_W-1:0] cfg_rdata,
   output logic              wait_hold,
   output logic [CNT_W-1:0]  wait_left
);
   localparam int unsigned NEED_W = bws_pkg::bws_len_width(CODE_W, STEP);

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code_w
         $error("bus_wait_stretcher: CODE_W out of range");
      end
      if (CNT_W < NEED_W) begin : g_bad_cnt_w
         $error("bus_wait_stretcher: CNT_W too narrow for the longest stretch");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic [CNT_W-1:0]  len;
   logic              start;

   bws_cfg_reg #(
      .CODE_W     (CODE_W),
      .RESET_CODE (RESET_CODE)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .code_q  (code)
   );

   bws_len_map #(
      .CODE_W (CODE_W),
      .STEP   (STEP),
      .CNT_W  (CNT_W)
   ) u_map (
      .code (code),
      .len  (len)
   );

   assign start = t3_done && ext_access && !slow_osc;

   bws_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (half_tick),
      .start (start),
      .len   (len),
      .hold  (wait_hold),
      .left  (wait_left)
   );

   assign cfg_rdata = code;
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned STEP   = 2,
   parameter int unsigned CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              half_tick,
   input logic              t3_done,
   input logic              ext_access,
   input logic              slow_osc,
   input logic              cfg_we,
   input logic [CODE_W-1:0] cfg_wdata,
   input logic [CODE_W-1:0] cfg_rdata,
   input logic              wait_hold,
   input logic [CNT_W-1:0]  wait_left
);
   logic [CNT_W-1:0] exp_len;
   assign exp_len = CNT_W'(cfg_rdata) * CNT_W'(STEP);

   assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

   assert_start_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_tick && t3_done && !wait_hold && ext_access && !slow_osc && exp_len != '0)
      |=> (wait_hold && wait_left == $past(exp_len)));

   assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (half_tick && !wait_hold && cfg_rdata == '0) |=> !wait_hold);

   assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (half_tick && wait_hold) |=> (wait_left == $past(wait_left) - CNT_W'(1)));

   assert_stable_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_tick) |=> ($stable(wait_left) && $stable(wait_hold)));

   assert_internal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_hold && !ext_access) |=> !wait_hold);

   assert_slow_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_hold && slow_osc) |=> !wait_hold);

   assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_hold && half_tick && t3_done) |=> (wait_left == $past(wait_left) - CNT_W'(1)));
endmodule

bind bus_wait_stretcher bws_checker #(
   .CODE_W (CODE_W),
   .STEP   (STEP),
   .CNT_W  (CNT_W)
) u_bws_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .half_tick  (half_tick),
   .t3_done    (t3_done),
   .ext_access (ext_access),
   .slow_osc   (slow_osc),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .wait_hold  (wait_hold),
   .wait_left  (wait_left)
);

// File: tb/bus_wait_stretcher_bench.sv
`timescale 1ns/1ps
module bus_wait_stretcher_bench;
   localparam int CODE_W = 3;
   localparam int CNT_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              half_tick = 1'b0;
   logic              t3_done = 1'b0;
   logic              ext_access = 1'b0;
   logic              slow_osc = 1'b0;
   logic              cfg_we = 1'b0;
   logic [CODE_W-1:0] cfg_wdata = '0;
   logic [CODE_W-1:0] cfg_rdata;
   logic              wait_hold;
   logic [CNT_W-1:0]  wait_left;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bus_wait_stretcher u_bus_wait_stretcher (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_tick  (half_tick),
      .t3_done    (t3_done),
      .ext_access (ext_access),
      .slow_osc   (slow_osc),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .wait_hold  (wait_hold),
      .wait_left  (wait_left)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_code(input int code);
      cfg_we = 1'b1;
      cfg_wdata = CODE_W'(code);
      step();
      cfg_we = 1'b0;
      check("R2 setting readback", int'(cfg_rdata), code);
   endtask

   // One bus cycle: T3-complete tick, then ticks until the hold drops.
   task automatic run_wait(input int code, input bit ext, input bit slow,
                           input int wr_at, input int wr_code, input bit t3_mid);
      int exp_len;
      int n;
      int prev;
      exp_len = (ext && !slow) ? 2 * code : 0;
      ext_access = ext;
      slow_osc = slow;
      half_tick = 1'b1;
      t3_done = 1'b1;
      step();
      half_tick = 1'b0;
      t3_done = 1'b0;
      // R3 R4 R5 R7 R8: hold and count right after the trigger tick
      check("R5 hold after trigger", int'(wait_hold), (exp_len != 0) ? 1 : 0);
      check("R3 loaded length", int'(wait_left), exp_len);
      n = 0;
      while (wait_hold && n < 40) begin
         prev = int'(wait_left);
         if (n == wr_at) begin
            cfg_we = 1'b1;
            cfg_wdata = CODE_W'(wr_code);
         end
         step();
         cfg_we = 1'b0;
         check("R6 stable without tick", int'(wait_left), prev);
         half_tick = 1'b1;
         t3_done = t3_mid;
         step();
         half_tick = 1'b0;
         t3_done = 1'b0;
         n++;
         check("R6 decrement per tick", int'(wait_left), prev - 1);
      end
      check("R3 R9 R10 total wait ticks", n, exp_len);
      check("R6 hold low at end", int'(wait_hold), 0);
      ext_access = 1'b0;
      slow_osc = 1'b0;
      step();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      step();
      step();
      check("R1 reset setting", int'(cfg_rdata), 0);
      check("R1 reset hold", int'(wait_hold), 0);
      check("R1 reset count", int'(wait_left), 0);
      rst_n = 1'b1;
      step();

      // R4: reset setting 000 gives no stretch on an external fast access
      run_wait(0, 1'b1, 1'b0, -1, 0, 1'b0);

      // R3 R7 R8: full sweep of settings and access conditions
      for (int c = 0; c < 8; c++) begin
         write_code(c);
         for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 2; s++) begin
               run_wait(c, e[0], s[0], -1, 0, 1'b0);
            end
         end
      end

      // R9: write 111 during a 6-state stretch; current stays 6, next is 14
      write_code(3);
      run_wait(3, 1'b1, 1'b0, 2, 7, 1'b0);
      check("R9 new setting visible", int'(cfg_rdata), 7);
      run_wait(7, 1'b1, 1'b0, -1, 0, 1'b0);

      // R10: T3-complete pulses during the hold do not restart it
      write_code(5);
      run_wait(5, 1'b1, 1'b0, -1, 0, 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule